// File: doc/BRIEF.md
# Bilinear Texel Address Generator

This block converts one normalised texture coordinate pair, together with a requested mip level, into the 2×2 group of integer texel coordinates that one bilinear filter operation reads. It also produces the two 8-bit blend weights that tell the filter how far the sample point lies between the columns and between the rows of that group. The base texture size is given per axis as a power of two. The selected level shrinks each axis by that power, and each axis has its own address mode: clamp to the edge or wrap around.

Requests enter on a valid/ready stream and results leave on another. The unit has two pipeline stages. It accepts one request per cycle whenever the consumer is ready, so a texture sampler can stream coordinates through it at full rate. When the consumer stalls, the whole pipeline holds its contents, and no result is dropped or overwritten.

Top module: `texel_addr_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The texel count of an axis at the used level is the base count (2 to the power `in_log_w` or `in_log_h`) shifted right by the used level, and it is never less than 1.
- R3: The used level is the requested level limited to the larger of `in_log_w` and `in_log_h`. A level above that limit gives the same result as the limit itself.
- R4: U and V are unsigned 16-bit values with 16 fractional bits. For each axis, p = coord × size − 0.5. The lower texel is floor(p) and the upper texel is floor(p)+1, both taken before address handling.
- R5: Each blend weight (`out_fu`, `out_fv`) is the top 8 bits of the fractional part of p for its axis, so p = −0.5 gives 0x80.
- R6: When the axis mode bit is 0 (clamp), each coordinate of that axis is limited to the range 0 to size−1, lower and upper texel independently.
- R7: When the axis mode bit is 1 (wrap), each coordinate of that axis is reduced modulo the size of the level.
- R8: Corner c occupies bits [c*10 +: 10] of `out_tx` and `out_ty`. Corner 0 is (lower x, lower y), corner 1 is (upper x, lower y), corner 2 is (lower x, upper y) and corner 3 is (upper x, upper y).
- R9: A request accepted at a clock edge appears on the outputs after the second edge that follows. Back-to-back requests come out on consecutive cycles.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output holds its value and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_u | input | 16 | Horizontal coordinate, 0.16 fixed point |
| in_v | input | 16 | Vertical coordinate, 0.16 fixed point |
| in_level | input | 4 | Requested mip level |
| in_log_w | input | 4 | log2 of the base width |
| in_log_h | input | 4 | log2 of the base height |
| in_mode_u | input | 1 | Horizontal mode: 0 clamp, 1 wrap |
| in_mode_v | input | 1 | Vertical mode: 0 clamp, 1 wrap |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_tx | output | 40 | Four 10-bit x coordinates, corner 0 in the low bits |
| out_ty | output | 40 | Four 10-bit y coordinates, corner 0 in the low bits |
| out_fu | output | 8 | Horizontal blend weight |
| out_fv | output | 8 | Vertical blend weight |

## Verification
Two things can happen to one axis in the same cycle: the lower texel falls below zero because of the half-texel shift, and the upper texel falls past the last texel of the level. Both are triggered with coordinates at 0 and near 1 on a level only a few texels wide, and on a level that is a single texel wide, where both corners land on the same texel. The expected corners come from the modulo and range rules applied to each corner separately, and each corner is compared with its expected value. A second overlap, a new request arriving while the consumer stalls, is triggered by holding `out_ready` low and checking that the held result stays the same and that `in_ready` stays low.

// File: rtl/texaddr_pkg.sv
package texaddr_pkg;

    typedef enum logic {
        ADDR_CLAMP = 1'b0,
        ADDR_WRAP  = 1'b1
    } addr_mode_e;

endpackage

// File: rtl/tag_level_sel.sv
module tag_level_sel #(
    parameter int LOG_MAX = 10,
    parameter int LVL_W   = 4,
    parameter int LW_W    = 4
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LW_W-1:0]  log_w,
    input  logic [LW_W-1:0]  log_h,
    output logic [LW_W-1:0]  lw,
    output logic [LW_W-1:0]  lh
);
    localparam int CW = (LVL_W > LW_W) ? LVL_W : LW_W;

    logic [LW_W-1:0] bw, bh, top, eff;
    logic [CW-1:0]   lvl_x, top_x;

    always_comb begin
        bw    = (log_w > LW_W'(LOG_MAX)) ? LW_W'(LOG_MAX) : log_w;
        bh    = (log_h > LW_W'(LOG_MAX)) ? LW_W'(LOG_MAX) : log_h;
        top   = (bw > bh) ? bw : bh;
        lvl_x = CW'(level);
        top_x = CW'(top);
        eff   = (lvl_x > top_x) ? top : LW_W'(lvl_x);
        lw    = (bw > eff) ? (bw - eff) : '0;
        lh    = (bh > eff) ? (bh - eff) : '0;
    end

endmodule

// File: rtl/tag_axis_front.sv
module tag_axis_front #(
    parameter int COORD_W = 16,
    parameter int LOG_MAX = 10,
    parameter int LW_W    = 4,
    parameter int FW      = 8,
    parameter int PW      = LOG_MAX + 2
) (
    input  logic [COORD_W-1:0] coord,
    input  logic [LW_W-1:0]    log_size,
    output logic [PW-1:0]      base,
    output logic [FW-1:0]      frac
);
    localparam int SW = COORD_W + LOG_MAX;
    localparam logic [SW:0] HALF = {{(SW+1-COORD_W){1'b0}}, 1'b1, {(COORD_W-1){1'b0}}};

    logic [SW-1:0] scaled;
    logic [SW:0]   shifted;

    always_comb begin
        scaled  = SW'(coord) << log_size;
        shifted = {1'b0, scaled} - HALF;
        base    = {shifted[SW], shifted[SW:COORD_W]};
        frac    = shifted[COORD_W-1 -: FW];
    end

endmodule

// File: rtl/tag_axis_resolve.sv
module tag_axis_resolve #(
    parameter int LOG_MAX = 10,
    parameter int LW_W    = 4,
    parameter int PW      = LOG_MAX + 2
) (
    input  logic [PW-1:0]      pos,
    input  logic [LW_W-1:0]    log_size,
    input  logic               wrap,
    output logic [LOG_MAX-1:0] coord
);
    logic [PW-1:0] mask;

    always_comb begin
        mask = (PW'(1) << log_size) - PW'(1);
        if (wrap) begin
            coord = pos[LOG_MAX-1:0] & mask[LOG_MAX-1:0];
        end else if (pos[PW-1]) begin
            coord = '0;
        end else if (pos > mask) begin
            coord = mask[LOG_MAX-1:0];
        end else begin
            coord = pos[LOG_MAX-1:0];
        end
    end

endmodule

// File: rtl/texel_addr_gen.sv
module texel_addr_gen #(
    parameter int COORD_W = 16,
    parameter int LOG_MAX = 10,
    parameter int LVL_W   = 4,
    parameter int FRAC_W  = 8,
    parameter int LW_W    = $clog2(LOG_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [COORD_W-1:0]     in_u,
    input  logic [COORD_W-1:0]     in_v,
    input  logic [LVL_W-1:0]       in_level,
    input  logic [LW_W-1:0]        in_log_w,
    input  logic [LW_W-1:0]        in_log_h,
    input  logic                   in_mode_u,
    input  logic                   in_mode_v,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [4*LOG_MAX-1:0]   out_tx,
    output logic [4*LOG_MAX-1:0]   out_ty,
    output logic [FRAC_W-1:0]      out_fu,
    output logic [FRAC_W-1:0]      out_fv
);
    import texaddr_pkg::*;

    localparam int PW = LOG_MAX + 2;
    localparam int AW = LOG_MAX;

    typedef struct packed {
        logic              valid;
        logic [PW-1:0]     x0;
        logic [PW-1:0]     y0;
        logic [FRAC_W-1:0] fu;
        logic [FRAC_W-1:0] fv;
        logic [LW_W-1:0]   lw;
        logic [LW_W-1:0]   lh;
        logic              wrap_u;
        logic              wrap_v;
    } stage1_t;

    typedef struct packed {
        logic              valid;
        logic [4*AW-1:0]   tx;
        logic [4*AW-1:0]   ty;
        logic [FRAC_W-1:0] fu;
        logic [FRAC_W-1:0] fv;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic              adv;
    logic [LW_W-1:0]   sel_lw, sel_lh;
    logic [PW-1:0]     base_in [2];
    logic [FRAC_W-1:0] frac_in [2];
    logic [LW_W-1:0]   size_s1 [2];
    logic              wrap_s1 [2];
    logic [PW-1:0]     base_s1 [2];
    logic [AW-1:0]     res     [2][2];

    tag_level_sel #(
        .LOG_MAX (LOG_MAX),
        .LVL_W   (LVL_W),
        .LW_W    (LW_W)
    ) u_level (
        .level (in_level),
        .log_w (in_log_w),
        .log_h (in_log_h),
        .lw    (sel_lw),
        .lh    (sel_lh)
    );

    always_comb begin
        base_s1[0] = pipe_q.s1.x0;
        base_s1[1] = pipe_q.s1.y0;
        size_s1[0] = pipe_q.s1.lw;
        size_s1[1] = pipe_q.s1.lh;
        wrap_s1[0] = pipe_q.s1.wrap_u;
        wrap_s1[1] = pipe_q.s1.wrap_v;
    end

    generate
        for (genvar a = 0; a < 2; a++) begin : g_axis
            tag_axis_front #(
                .COORD_W (COORD_W),
                .LOG_MAX (LOG_MAX),
                .LW_W    (LW_W),
                .FW      (FRAC_W),
                .PW      (PW)
            ) u_front (
                .coord    ((a == 0) ? in_u : in_v),
                .log_size ((a == 0) ? sel_lw : sel_lh),
                .base     (base_in[a]),
                .frac     (frac_in[a])
            );
            for (genvar o = 0; o < 2; o++) begin : g_side
                tag_axis_resolve #(
                    .LOG_MAX (LOG_MAX),
                    .LW_W    (LW_W),
                    .PW      (PW)
                ) u_resolve (
                    .pos      (base_s1[a] + PW'(o)),
                    .log_size (size_s1[a]),
                    .wrap     (wrap_s1[a]),
                    .coord    (res[a][o])
                );
            end
        end
    endgenerate

    assign adv = !pipe_q.s2.valid || out_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (adv) begin
            pipe_d.s1.valid  = in_valid;
            pipe_d.s1.x0     = base_in[0];
            pipe_d.s1.y0     = base_in[1];
            pipe_d.s1.fu     = frac_in[0];
            pipe_d.s1.fv     = frac_in[1];
            pipe_d.s1.lw     = sel_lw;
            pipe_d.s1.lh     = sel_lh;
            pipe_d.s1.wrap_u = (in_mode_u == ADDR_WRAP);
            pipe_d.s1.wrap_v = (in_mode_v == ADDR_WRAP);

            pipe_d.s2.valid  = pipe_q.s1.valid;
            pipe_d.s2.tx     = {res[0][1], res[0][0], res[0][1], res[0][0]};
            pipe_d.s2.ty     = {res[1][1], res[1][1], res[1][0], res[1][0]};
            pipe_d.s2.fu     = pipe_q.s1.fu;
            pipe_d.s2.fv     = pipe_q.s1.fv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign in_ready  = adv;
    assign out_valid = pipe_q.s2.valid;
    assign out_tx    = pipe_q.s2.tx;
    assign out_ty    = pipe_q.s2.ty;
    assign out_fu    = pipe_q.s2.fu;
    assign out_fv    = pipe_q.s2.fv;

endmodule

// File: rtl/texel_addr_gen_chk.sv
module texel_addr_gen_chk #(
    parameter int AW = 10,
    parameter int FW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [4*AW-1:0] out_tx,
    input logic [4*AW-1:0] out_ty,
    input logic [FW-1:0] out_fu,
    input logic [FW-1:0] out_fv
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

    AST_TWO_STAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 out_valid); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tx) && $stable(out_ty)
                                       && $stable(out_fu) && $stable(out_fv))); // R10

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10

    AST_COLUMN_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tx[0 +: AW] == out_tx[2*AW +: AW])
                   && (out_tx[AW +: AW] == out_tx[3*AW +: AW])); // R8

    AST_ROW_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ty[0 +: AW] == out_ty[AW +: AW])
                   && (out_ty[2*AW +: AW] == out_ty[3*AW +: AW])); // R8

endmodule

bind texel_addr_gen texel_addr_gen_chk #(
    .AW (LOG_MAX),
    .FW (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tx    (out_tx),
    .out_ty    (out_ty),
    .out_fu    (out_fu),
    .out_fv    (out_fv)
);

// File: tb/texel_addr_gen_test.sv
module texel_addr_gen_test;

    typedef struct packed {
        logic [15:0] u;
        logic [15:0] v;
        logic [3:0]  lvl;
        logic [3:0]  lw;
        logic [3:0]  lh;
        logic        mu;
        logic        mv;
        logic [9:0]  x0;
        logic [9:0]  x1;
        logic [9:0]  y0;
        logic [9:0]  y1;
        logic [7:0]  fu;
        logic [7:0]  fv;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{16'h8000, 16'h8000, 4'd0, 4'd3,  4'd3,  1'b0, 1'b0, 10'd3,    10'd4, 10'd3, 10'd4, 8'h80, 8'h80},
        '{16'h0000, 16'h0000, 4'd0, 4'd3,  4'd3,  1'b1, 1'b0, 10'd7,    10'd0, 10'd0, 10'd0, 8'h80, 8'h80},
        '{16'hFFFF, 16'hF000, 4'd0, 4'd3,  4'd3,  1'b0, 1'b1, 10'd7,    10'd7, 10'd7, 10'd0, 8'h7F, 8'h00},
        '{16'h4000, 16'h4000, 4'd1, 4'd4,  4'd2,  1'b0, 1'b0, 10'd1,    10'd2, 10'd0, 10'd1, 8'h80, 8'h00},
        '{16'h8000, 16'h1234, 4'd7, 4'd2,  4'd3,  1'b0, 1'b1, 10'd0,    10'd0, 10'd0, 10'd0, 8'h00, 8'h92},
        '{16'hC000, 16'hC000, 4'd2, 4'd3,  4'd1,  1'b1, 1'b0, 10'd1,    10'd0, 10'd0, 10'd0, 8'h00, 8'h40},
        '{16'hFFFF, 16'h0040, 4'd0, 4'd10, 4'd10, 1'b1, 1'b0, 10'd1023, 10'd0, 10'd0, 10'd1, 8'h7C, 8'h80}
    };
    localparam string TAG [NV] = '{
        "R4 R5 R6", "R7 R6 R5", "R6 R7 R5", "R2 R4", "R3 R6 R7", "R2 R7 R6", "R7 R5 R4"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_u = '0;
    logic [15:0] in_v = '0;
    logic [3:0]  in_level = '0;
    logic [3:0]  in_log_w = '0;
    logic [3:0]  in_log_h = '0;
    logic        in_mode_u = 1'b0;
    logic        in_mode_v = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [39:0] out_tx, out_ty;
    logic [7:0]  out_fu, out_fv;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    texel_addr_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_u      (in_u),
        .in_v      (in_v),
        .in_level  (in_level),
        .in_log_w  (in_log_w),
        .in_log_h  (in_log_h),
        .in_mode_u (in_mode_u),
        .in_mode_v (in_mode_v),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_tx    (out_tx),
        .out_ty    (out_ty),
        .out_fu    (out_fu),
        .out_fv    (out_fv)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t t);
        in_u      = t.u;
        in_v      = t.v;
        in_level  = t.lvl;
        in_log_w  = t.lw;
        in_log_h  = t.lh;
        in_mode_u = t.mu;
        in_mode_v = t.mv;
    endtask

    task automatic check_vec(input int i, input string ctx);
        vec_t t;
        t = TBL[i];
        chk({ctx, " ", TAG[i], " valid"}, 64'(out_valid), 64'd1);
        chk({ctx, " ", TAG[i], " R8 tx"}, 64'(out_tx), 64'({t.x1, t.x0, t.x1, t.x0}));
        chk({ctx, " ", TAG[i], " R8 ty"}, 64'(out_ty), 64'({t.y1, t.y1, t.y0, t.y0}));
        chk({ctx, " ", TAG[i], " fu"}, 64'(out_fu), 64'(t.fu));
        chk({ctx, " ", TAG[i], " fv"}, 64'(out_fv), 64'(t.fv));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", 64'(out_valid), 64'd0);
        chk("R1 in_ready in reset", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", 64'(out_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check_vec(i, "vector");
        end

        // R9: back-to-back requests, one result per cycle after two edges
        @(negedge clk);
        chk("R9 idle before burst", 64'(out_valid), 64'd0);
        drive(TBL[0]); in_valid = 1'b1;
        @(negedge clk);
        drive(TBL[3]);
        @(negedge clk);
        check_vec(0, "R9 burst first");
        drive(TBL[6]);
        @(negedge clk);
        check_vec(3, "R9 burst second");
        in_valid = 1'b0;
        @(negedge clk);
        check_vec(6, "R9 burst third");
        @(negedge clk);
        chk("R9 burst drained", 64'(out_valid), 64'd0);

        // R10: consumer stall holds the result and blocks input
        out_ready = 1'b0;
        drive(TBL[1]); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_vec(1, "R10 stalled");
        drive(TBL[2]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 in_ready low in stall", 64'(in_ready), 64'd0);
            check_vec(1, "R10 held");
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R10 released and empty", 64'(out_valid), 64'd0);
        chk("R10 in_ready after release", 64'(in_ready), 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule